// File: doc/BRIEF.md
# Hashed Page Table Searcher

This block walks an in-memory hashed page table after a translation miss. Given a 32-bit effective address, the segment value covering it and the table base/size register, it works out the address of a 64-byte entry group and a 32-bit compare tag. It then reads the first word of each of the eight two-word entries in that group over a word-wide memory port, looking for a word equal to the tag. If the first group has no match, it repeats the search in a second group and with a second tag.

When an entry matches, the block reads its second word and forms the physical page address from it. It decodes the read and write rights from a two-bit protection field together with a key bit, which it picks from the segment value according to the privilege level. It then marks the entry as referenced and, for a permitted store, as changed. Each of these marks is written to memory as a single byte. The result is reported with a one-cycle done pulse: success, protection fault, or not found.

A lookup starts with a one-cycle `start` pulse while the block is idle. The caller holds the memory side, which answers each request with an acknowledge.

Top module: `hpt_walker`

## Requirements
- R1: After reset, `done`, `hit`, `mem_req`, `perm_r`, `perm_w` and `perm_x` are 0, and `fault` is 0.
- R2: The first request of a lookup reads the first word of entry 0 of the primary group. The group address is `{tbl[31:16],16'h0} | (H & M)`, where H = ({4'b0,seg[27:0]} ^ ea[27:12]) << 6 and M = {7'b0,tbl[8:0],16'h0} | 32'hFFC0.
- R3: The secondary group uses ~H in place of H. It is searched only after all eight entries of the primary group fail to match. A lookup with no match anywhere makes exactly 16 reads.
- R4: An entry matches when its first word equals 32'h8000_0000 | (secondary ? 32'h40 : 0) | (seg[27:0] << 7) | ea[27:22]. Entry k of a group starts at byte offset 8k, and its second word sits at offset 8k+4.
- R5: On a match, `pa` is the second word with its low 12 bits replaced by `ea[11:0]`.
- R6: The key bit is `seg[29]` when `user`=1 and `seg[30]` when `user`=0. The protection code is {key, second word[1:0]}.
- R7: Codes 0, 1, 2 and 6 grant read and write. Codes 3, 5 and 7 grant read only. Code 4 grants neither. `perm_x` is 1 for every matched entry.
- R8: If read is granted and second-word bit 8 is clear, the block writes the second word with `mem_be`=4'b0010 to set that bit. Bytes are mapped so that `mem_be[i]` covers data bits 8i+7:8i.
- R9: If `store`=1, write is granted and second-word bit 7 is clear, the block writes with `mem_be`=4'b0001 to set that bit. It does this after any write from R8.
- R10: `fault` codes: 0 = success, with `hit`=1. 1 = not found. 2 = protection fault, for a matched entry with no read right, or a store with no write right. For codes 1 and 2, `hit` is 0.
- R11: The port carries one request at a time. `mem_req`, `mem_addr`, `mem_we` and `mem_be` hold steady until `mem_ack`. Writes go only to second words and enable exactly one byte.
- R12: `done` is high for one cycle per lookup. A `start` pulse while a lookup is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a lookup (taken only when idle) |
| ea | input | 32 | Effective address to translate |
| seg | input | 32 | Segment value: bits 27:0 id, bit 30 supervisor key, bit 29 user key |
| tbl | input | 32 | Table register: bits 31:16 base, bits 8:0 size mask |
| user | input | 1 | 1 = user-mode access |
| store | input | 1 | 1 = write access |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | Translation succeeded |
| fault | output | 2 | 0 ok, 1 not found, 2 protection |
| pa | output | 32 | Physical address |
| perm_r | output | 1 | Read granted |
| perm_w | output | 1 | Write granted |
| perm_x | output | 1 | Execute granted |

## Verification
The checker watches the memory handshake on every cycle. It confirms that a pending request stays steady until acknowledged, that every write targets a second word with exactly one byte enabled, and that `done` is a single-cycle pulse whose `hit` agrees with the fault code. Whether the hash, the tag and the protection decode produce the right answers can only be shown by the bench's scenarios. These place entries in primary and secondary groups, include a decoy that carries the secondary tag in the primary group, and cover both key bits. After each lookup the bench counts reads and writes and inspects the updated entry in the bench memory.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int XLEN = 32;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_MISS = 2'd1,
    FLT_PROT = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TAG,
    S_DATA,
    S_EVAL,
    S_SET_REF,
    S_SET_CHG
  } walk_e;

  localparam logic [XLEN-1:0] TAG_VALID = 32'h8000_0000;
  localparam logic [XLEN-1:0] TAG_SEC   = 32'h0000_0040;
  localparam logic [XLEN-1:0] REF_BIT   = 32'h0000_0100;
  localparam logic [XLEN-1:0] CHG_BIT   = 32'h0000_0080;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash
  import hpt_pkg::*;
#(
  parameter int GRP_SHIFT = 6
) (
  input  logic [27:0]     vsid,
  input  logic [15:0]     page,
  input  logic [15:0]     tbl_base,
  input  logic [8:0]      tbl_mask,
  input  logic            sec,
  output logic [XLEN-1:0] grp,
  output logic [XLEN-1:0] tag
);
  localparam logic [XLEN-1:0] LOW_MASK =
    32'h0000_FFFF & ~((32'd1 << GRP_SHIFT) - 32'd1);

  logic [XLEN-1:0] raw, sel, mask;

  always_comb begin
    raw  = ({4'b0, vsid} ^ {16'b0, page}) << GRP_SHIFT;
    sel  = sec ? ~raw : raw;
    mask = {7'b0, tbl_mask, 16'h0} | LOW_MASK;
    grp  = {tbl_base, 16'h0} | (sel & mask);
    tag  = TAG_VALID | (sec ? TAG_SEC : '0) | ({4'b0, vsid} << 7) |
           {26'b0, page[15:10]};
  end
endmodule

// File: rtl/hpt_perm.sv
module hpt_perm (
  input  logic [1:0] pp_lo,
  input  logic       key_sup,
  input  logic       key_usr,
  input  logic       user,
  output logic       rd,
  output logic       wr
);
  logic [2:0] code;

  always_comb begin
    code = {(user ? key_usr : key_sup), pp_lo};
    rd   = 1'b0;
    wr   = 1'b0;
    unique case (code)
      3'd0, 3'd1, 3'd2, 3'd6: begin rd = 1'b1; wr = 1'b1; end
      3'd3, 3'd5, 3'd7:       begin rd = 1'b1; wr = 1'b0; end
      default:                begin rd = 1'b0; wr = 1'b0; end
    endcase
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int GRP_SHIFT = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] ea,
  input  logic [31:0] seg,
  input  logic [31:0] tbl,
  input  logic        user,
  input  logic        store,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic        hit,
  output logic [1:0]  fault,
  output logic [31:0] pa,
  output logic        perm_r,
  output logic        perm_w,
  output logic        perm_x
);
  localparam int ENTRIES = (1 << GRP_SHIFT) / 8;
  localparam int IDXW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDXW-1:0] LAST = IDXW'(ENTRIES - 1);

  walk_e           state;
  fault_e          fault_q;
  logic [11:0]     off_q;
  logic [15:0]     page_q;
  logic [27:0]     vsid_q;
  logic            ksup_q, kusr_q;
  logic [15:0]     base_q;
  logic [8:0]      tmask_q;
  logic            user_q, store_q, sec_q;
  logic [IDXW-1:0] idx_q;
  logic [31:0]     w1_q;

  logic [31:0] grp, tag, ent_off;
  logic        rd_ok, wr_ok, need_ref, need_chg, finish_hit, finish_miss;
  logic        unused_ok;

  assign unused_ok = ^{ea[31:28], seg[31], tbl[15:9]};

  hpt_hash #(.GRP_SHIFT(GRP_SHIFT)) u_hash (
    .vsid(vsid_q), .page(page_q), .tbl_base(base_q), .tbl_mask(tmask_q),
    .sec(sec_q), .grp(grp), .tag(tag)
  );

  hpt_perm u_perm (
    .pp_lo(w1_q[1:0]), .key_sup(ksup_q), .key_usr(kusr_q), .user(user_q),
    .rd(rd_ok), .wr(wr_ok)
  );

  always_comb begin
    ent_off   = 32'(idx_q) << 3;
    mem_req   = (state == S_TAG) || (state == S_DATA) ||
                (state == S_SET_REF) || (state == S_SET_CHG);
    mem_we    = (state == S_SET_REF) || (state == S_SET_CHG);
    mem_addr  = grp | ent_off | ((state == S_TAG) ? 32'd0 : 32'd4);
    mem_be    = (state == S_SET_REF) ? 4'b0010 :
                (state == S_SET_CHG) ? 4'b0001 : 4'b1111;
    mem_wdata = w1_q | REF_BIT | CHG_BIT;
    need_ref  = rd_ok && !w1_q[8];
    need_chg  = store_q && wr_ok && !w1_q[7];
    finish_hit  = (state == S_EVAL && !need_ref && !need_chg) ||
                  (state == S_SET_REF && mem_ack && !need_chg) ||
                  (state == S_SET_CHG && mem_ack);
    finish_miss = (state == S_TAG) && mem_ack && (mem_rdata != tag) &&
                  (idx_q == LAST) && sec_q;
  end

  assign fault = fault_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      fault_q <= FLT_NONE;
      done    <= 1'b0;
      hit     <= 1'b0;
      pa      <= '0;
      perm_r  <= 1'b0;
      perm_w  <= 1'b0;
      perm_x  <= 1'b0;
      off_q   <= '0;
      page_q  <= '0;
      vsid_q  <= '0;
      ksup_q  <= 1'b0;
      kusr_q  <= 1'b0;
      base_q  <= '0;
      tmask_q <= '0;
      user_q  <= 1'b0;
      store_q <= 1'b0;
      sec_q   <= 1'b0;
      idx_q   <= '0;
      w1_q    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          off_q   <= ea[11:0];
          page_q  <= ea[27:12];
          vsid_q  <= seg[27:0];
          ksup_q  <= seg[30];
          kusr_q  <= seg[29];
          base_q  <= tbl[31:16];
          tmask_q <= tbl[8:0];
          user_q  <= user;
          store_q <= store;
          sec_q   <= 1'b0;
          idx_q   <= '0;
          state   <= S_TAG;
        end
        S_TAG: if (mem_ack) begin
          if (mem_rdata == tag) begin
            state <= S_DATA;
          end else if (idx_q == LAST) begin
            idx_q <= '0;
            sec_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_DATA: if (mem_ack) begin
          w1_q  <= mem_rdata;
          state <= S_EVAL;
        end
        S_EVAL: begin
          pa    <= {w1_q[31:12], off_q};
          state <= need_ref ? S_SET_REF : S_SET_CHG;
        end
        S_SET_REF: if (mem_ack) state <= S_SET_CHG;
        S_SET_CHG: ;
        default: state <= S_IDLE;
      endcase

      if (finish_hit) begin
        state   <= S_IDLE;
        done    <= 1'b1;
        perm_r  <= rd_ok;
        perm_w  <= wr_ok;
        perm_x  <= 1'b1;
        hit     <= rd_ok && !(store_q && !wr_ok);
        fault_q <= (rd_ok && !(store_q && !wr_ok)) ? FLT_NONE : FLT_PROT;
      end
      if (finish_miss) begin
        state   <= S_IDLE;
        done    <= 1'b1;
        hit     <= 1'b0;
        fault_q <= FLT_MISS;
        pa      <= '0;
        perm_r  <= 1'b0;
        perm_w  <= 1'b0;
        perm_x  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk (
  input logic        clk,
  input logic        rst,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic        mem_ack,
  input logic        done,
  input logic        hit,
  input logic [1:0]  fault,
  input logic        perm_r,
  input logic        perm_x
);
  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_be));

  a_r11_write_second_word: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_addr[2] && (mem_addr[1:0] == 2'b00));

  a_r8_single_byte: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> $countones(mem_be) == 1);

  a_r9_chg_lane: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we && !mem_be[1] |-> mem_be[0]);

  a_r10_hit_code: assert property (@(posedge clk) disable iff (rst)
    done |-> (hit == (fault == 2'd0)) && (fault != 2'd3));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);

  a_r7_exec_on_hit: assert property (@(posedge clk) disable iff (rst)
    done && hit |-> perm_x && perm_r);
endmodule

bind hpt_walker hpt_walker_chk u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_be(mem_be), .mem_ack(mem_ack), .done(done),
  .hit(hit), .fault(fault), .perm_r(perm_r), .perm_x(perm_x)
);

// File: tb/tb_hpt_walker.sv
module tb_hpt_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] ea = '0, seg = '0, tbl = '0;
  logic        user = 1'b0, store = 1'b0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        done, hit, perm_r, perm_w, perm_x;
  logic [1:0]  fault;
  logic [31:0] pa;

  always #5 clk = ~clk;

  hpt_walker dut (
    .clk(clk), .rst(rst), .start(start), .ea(ea), .seg(seg), .tbl(tbl),
    .user(user), .store(store), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .hit(hit),
    .fault(fault), .pa(pa), .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
  );

  int tests = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
  logic [31:0] first_rd = '0;
  logic [31:0] mem [logic [31:0]];

  function automatic logic [31:0] mem_get(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory model: acknowledges one cycle after each request
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (done) done_cnt = done_cnt + 1;
      if (mem_req && !mem_ack) begin
        mem_rdata <= mem_get(mem_addr);
        if (mem_we) begin
          logic [31:0] w;
          w = mem_get(mem_addr);
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) w[8*b +: 8] = mem_wdata[8*b +: 8];
          mem[mem_addr] = w;
          wr_cnt = wr_cnt + 1;
        end else begin
          if (rd_cnt == 0) first_rd = mem_addr;
          rd_cnt = rd_cnt + 1;
        end
      end
    end
  end

  function automatic logic [31:0] f_grp(input logic [31:0] a, s, t, input logic sec);
    logic [31:0] h;
    h = ({4'b0, s[27:0]} ^ {16'b0, a[27:12]}) << 6;
    if (sec) h = ~h;
    h = h & ({7'b0, t[8:0], 16'h0} | 32'h0000_FFC0);
    return {t[31:16], 16'h0} | h;
  endfunction

  function automatic logic [31:0] f_tag(input logic [31:0] a, s, input logic sec);
    return 32'h8000_0000 | (sec ? 32'h40 : 32'h0) | ({4'b0, s[27:0]} << 7) |
           {26'b0, a[27:22]};
  endfunction

  task automatic chk(input logic ok, input string what, input logic [31:0] act, exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] ea, seg, tbl;
    logic        user, store;
    logic [1:0]  place;  // 0 none, 1 primary, 2 secondary, 3 decoy
    logic [2:0]  slot;
    logic [31:0] w1;
    logic [1:0]  flt;
    logic        r, w;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{32'h1234_5678, 32'h0000_0ABC, 32'h0020_0001, 1'b0, 1'b1, 2'd1, 3'd3, 32'h0040_1002, 2'd0, 1'b1, 1'b1},
    '{32'h0FFF_F123, 32'h2000_0123, 32'h0020_0001, 1'b1, 1'b0, 2'd2, 3'd0, 32'h0055_5001, 2'd0, 1'b1, 1'b0},
    '{32'h4000_1000, 32'h2000_0777, 32'h0020_0001, 1'b1, 1'b0, 2'd1, 3'd7, 32'h0012_3000, 2'd2, 1'b0, 1'b0},
    '{32'h8765_4321, 32'h4012_3456, 32'h0020_0001, 1'b0, 1'b1, 2'd1, 3'd0, 32'h0ABC_D182, 2'd0, 1'b1, 1'b1},
    '{32'hABCD_EFFF, 32'h4000_0FFF, 32'h0020_0001, 1'b0, 1'b1, 2'd2, 3'd7, 32'h0777_7003, 2'd2, 1'b1, 1'b0},
    '{32'h0000_0000, 32'h0000_0000, 32'h0020_0001, 1'b0, 1'b0, 2'd0, 3'd0, 32'h0000_0000, 2'd1, 1'b0, 1'b0},
    '{32'h3333_3333, 32'h0000_0042, 32'h0020_0001, 1'b0, 1'b0, 2'd3, 3'd2, 32'h0100_0002, 2'd1, 1'b0, 1'b0},
    '{32'h5555_5AAA, 32'h4000_0099, 32'h0020_0001, 1'b1, 1'b0, 2'd1, 3'd5, 32'h0F0F_0103, 2'd0, 1'b1, 1'b0},
    '{32'hCAFE_B00C, 32'h2000_0321, 32'h0030_01FF, 1'b0, 1'b1, 2'd1, 3'd1, 32'h0222_2001, 2'd0, 1'b1, 1'b1}
  };

  task automatic launch(input vec_t v);
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0;
    ea = v.ea; seg = v.seg; tbl = v.tbl; user = v.user; store = v.store;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output logic seen);
    seen = 1'b0;
    for (int c = 0; c < 400 && !seen; c++) begin
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic run_vec(input vec_t v, input int n);
    logic [31:0] e_addr, w1_addr, exp_w1;
    logic seen;
    int exp_rd, exp_wr;
    mem.delete();
    e_addr = '0;
    if (v.place == 2'd1) e_addr = f_grp(v.ea, v.seg, v.tbl, 1'b0) + 32'(v.slot) * 8;
    if (v.place == 2'd2) e_addr = f_grp(v.ea, v.seg, v.tbl, 1'b1) + 32'(v.slot) * 8;
    if (v.place == 2'd3) e_addr = f_grp(v.ea, v.seg, v.tbl, 1'b0) + 32'(v.slot) * 8;
    w1_addr = e_addr + 32'd4;
    if (v.place != 2'd0) begin
      mem[e_addr]  = f_tag(v.ea, v.seg, v.place == 2'd2 || v.place == 2'd3);
      mem[w1_addr] = v.w1;
    end
    exp_rd = (v.place == 2'd1) ? int'(v.slot) + 2 :
             (v.place == 2'd2) ? 8 + int'(v.slot) + 2 : 16;
    exp_wr = 0;
    exp_w1 = v.w1;
    if (v.flt != 2'd1) begin
      if (v.r && !v.w1[8]) begin exp_wr++; exp_w1[8] = 1'b1; end
      if (v.store && v.w && !v.w1[7]) begin exp_wr++; exp_w1[7] = 1'b1; end
    end
    launch(v);
    wait_done(seen);
    chk(seen, $sformatf("R12 vec%0d done seen", n), 32'(seen), 32'd1);
    chk(fault == v.flt, $sformatf("R10 vec%0d fault", n), 32'(fault), 32'(v.flt));
    chk(hit == (v.flt == 2'd0), $sformatf("R10 vec%0d hit", n), 32'(hit), 32'(v.flt == 2'd0));
    chk(first_rd == f_grp(v.ea, v.seg, v.tbl, 1'b0), $sformatf("R2 vec%0d first read", n),
        first_rd, f_grp(v.ea, v.seg, v.tbl, 1'b0));
    chk(rd_cnt == exp_rd, $sformatf("R3 R4 vec%0d read count", n), 32'(rd_cnt), 32'(exp_rd));
    chk(wr_cnt == exp_wr, $sformatf("R8 R9 vec%0d write count", n), 32'(wr_cnt), 32'(exp_wr));
    if (v.flt != 2'd1) begin
      chk(pa == {v.w1[31:12], v.ea[11:0]}, $sformatf("R5 vec%0d pa", n), pa, {v.w1[31:12], v.ea[11:0]});
      chk({perm_r, perm_w, perm_x} == {v.r, v.w, 1'b1}, $sformatf("R6 R7 vec%0d perms", n),
          32'({perm_r, perm_w, perm_x}), 32'({v.r, v.w, 1'b1}));
      chk(mem_get(w1_addr) == exp_w1, $sformatf("R8 R9 vec%0d entry bits", n), mem_get(w1_addr), exp_w1);
    end
    @(negedge clk);
  endtask

  initial begin
    logic seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !hit && !mem_req && fault == 2'd0 && !perm_r && !perm_w && !perm_x,
        "R1 reset outputs", 32'({done, hit, mem_req, fault, perm_r, perm_w, perm_x}), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_req && !done, "R1 idle after reset", 32'({mem_req, done}), 32'd0);

    for (int i = 0; i < 9; i++) run_vec(VEC[i], i);

    // R12: a second start while busy is ignored
    mem.delete();
    mem[f_grp(VEC[0].ea, VEC[0].seg, VEC[0].tbl, 1'b0) + 32'd24] = f_tag(VEC[0].ea, VEC[0].seg, 1'b0);
    mem[f_grp(VEC[0].ea, VEC[0].seg, VEC[0].tbl, 1'b0) + 32'd28] = VEC[0].w1;
    launch(VEC[0]);
    @(negedge clk);
    ea = 32'h0000_0000; seg = 32'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(seen);
    chk(seen && hit && pa == {VEC[0].w1[31:12], VEC[0].ea[11:0]}, "R12 busy start ignored",
        pa, {VEC[0].w1[31:12], VEC[0].ea[11:0]});
    repeat (60) @(negedge clk);
    chk(done_cnt == 1, "R12 single done pulse", 32'(done_cnt), 32'd1);
    chk(rd_cnt == 5, "R12 no extra lookup reads", 32'(rd_cnt), 32'd5);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R12 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule